// File: doc/BRIEF.md
# Pattern Checker with Link Hysteresis

This block sits on the receive side of a serial test link, after deserialisation and word alignment. Each cycle in which `rx_valid` is high it takes one parallel word. It predicts what that word should be under the selected test pattern and flags a mismatch. It also runs a link indicator that needs a run of clean words to come up and a run of errored words to go down.

The predictor keeps a history of the most recent stream bits. While the link is down, the history is loaded from the received words, so the predictor locks onto a stream whatever phase it arrives in. Once the link is up, the predictor runs on its own predictions, so a corrupted word cannot knock it out of step. Two saturating accumulators count received words and errored words. Software can zero them at any time without touching the link state.

Top module: `prbs_link_checker`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `link_up` and `word_err` are 0 and both counts are 0.
- R2: `pat_sel` selects the pattern as follows, where b(n) is stream bit n:
  - 0: b(n)=b(n-6)^b(n-7)
  - 1: b(n)=b(n-14)^b(n-15)
  - 2: b(n)=b(n-18)^b(n-23)
  - 3: b(n)=b(n-28)^b(n-31)
  - 4: alternating, b(n)=~b(n-1)
  - 5: ten ones then ten zeros, b(n)=~b(n-10)
  - 6 and 7 behave as 0.

  The word MSB is the earliest bit in time. `word_err` is 1 in the cycle after a valid word when any bit of that word differs from the prediction, and is 0 otherwise.
- R3: While the link is down, the predictor history is refilled from each received word. While the link is up, it is refilled from the predicted word, so one corrupted word leaves the next clean word unflagged.
- R4: With the link down, the fifth consecutive clean valid word raises `link_up` one cycle after that word.
- R5: With the link up, the fifth consecutive errored valid word drops `link_up` one cycle after that word.
- R6: A clean word restarts the errored run and an errored word restarts the clean run. Cycles with `rx_valid` low break neither run.
- R7: `word_count` increases by one for each valid word.
- R8: `err_count` increases by one for each errored valid word.
- R9: `cnt_clear` zeroes both counts on the next edge, overriding any increment. `link_up` is unaffected.
- R10: Both counts stop at their all-ones value and do not wrap.
- R11: A change of `pat_sel` (made with `rx_valid` low) drops `link_up` on the next edge and clears both runs.
- R12: With `rx_valid` low, `word_err` is 0 and the counts, the runs and the predictor history do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | W | Received aligned word, MSB earliest |
| rx_valid | input | 1 | Word strobe |
| pat_sel | input | 3 | Pattern select |
| cnt_clear | input | 1 | Zero both accumulators |
| link_up | output | 1 | Link indicator with hysteresis |
| word_err | output | 1 | Mismatch flag for the previous valid word |
| word_count | output | CNT_W | Received word count, saturating |
| err_count | output | CNT_W | Errored word count, saturating |

## Verification
Every result (`word_err`, `link_up` and both counts) comes from a register that is updated on the edge that accepts the word. Each result is therefore due exactly one edge after its inputs are presented. The bench drives inputs at the falling edge and samples one time unit after the next rising edge. Before each sample it advances its own reference model by exactly one word, so every comparison lines up with the single register stage. The run thresholds are checked at the fourth and fifth word of a run. Saturation is checked with a narrowed count width.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int HIST_W = 31;

  typedef enum logic [2:0] {
    PAT_P7  = 3'd0,
    PAT_P15 = 3'd1,
    PAT_P23 = 3'd2,
    PAT_P31 = 3'd3,
    PAT_ALT = 3'd4,
    PAT_TEN = 3'd5
  } pat_e;

  typedef struct packed {
    logic [4:0] near_tap;
    logic [4:0] far_tap;
    logic       invert;
  } rule_t;

  function automatic rule_t rule_of(input logic [2:0] sel);
    rule_t r;
    case (pat_e'(sel))
      PAT_P15: r = '{near_tap: 5'd14, far_tap: 5'd15, invert: 1'b0};
      PAT_P23: r = '{near_tap: 5'd18, far_tap: 5'd23, invert: 1'b0};
      PAT_P31: r = '{near_tap: 5'd28, far_tap: 5'd31, invert: 1'b0};
      PAT_ALT: r = '{near_tap: 5'd1,  far_tap: 5'd1,  invert: 1'b1};
      PAT_TEN: r = '{near_tap: 5'd10, far_tap: 5'd10, invert: 1'b1};
      default: r = '{near_tap: 5'd6,  far_tap: 5'd7,  invert: 1'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_chk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [2:0]        sel,
  output logic [W-1:0]      expect_word
);
  localparam int SPAN = HIST_W + W;

  rule_t            rule;
  logic [SPAN-1:0]  stream;

  always_comb begin
    rule   = rule_of(sel);
    stream = {hist, {W{1'b0}}};
    for (int p = W - 1; p >= 0; p--) begin
      if (rule.invert)
        stream[p] = ~stream[p + int'(rule.near_tap)];
      else
        stream[p] = stream[p + int'(rule.near_tap)] ^ stream[p + int'(rule.far_tap)];
    end
    expect_word = stream[W-1:0];
  end
endmodule

// File: rtl/prbs_sat_counter.sv
module prbs_sat_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else if (inc && (q != '1))
      q <= q + 1'b1;
  end
endmodule

// File: rtl/prbs_link_tracker.sv
module prbs_link_tracker #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic valid,
  input  logic bad,
  output logic link
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_LEN);

  logic [RW-1:0] clean_run, bad_run, clean_nx, bad_nx;
  logic          link_nx;

  always_comb begin
    if (bad) begin
      clean_nx = '0;
      bad_nx   = (bad_run == RUN_TOP) ? bad_run : bad_run + 1'b1;
    end else begin
      bad_nx   = '0;
      clean_nx = (clean_run == RUN_TOP) ? clean_run : clean_run + 1'b1;
    end
    if (link)
      link_nx = !(bad && (bad_nx == RUN_TOP));
    else
      link_nx = !bad && (clean_nx == RUN_TOP);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      clean_run <= '0;
      bad_run   <= '0;
      link      <= 1'b0;
    end else if (valid) begin
      clean_run <= clean_nx;
      bad_run   <= bad_nx;
      link      <= link_nx;
    end
  end
endmodule

// File: rtl/prbs_link_checker.sv
module prbs_link_checker
  import prbs_chk_pkg::*;
#(
  parameter int W       = 16,
  parameter int CNT_W   = 48,
  parameter int RUN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rx_data,
  input  logic             rx_valid,
  input  logic [2:0]       pat_sel,
  input  logic             cnt_clear,
  output logic             link_up,
  output logic             word_err,
  output logic [CNT_W-1:0] word_count,
  output logic [CNT_W-1:0] err_count
);
  localparam int N_ACC = 2;

  logic [HIST_W-1:0] hist;
  logic [2:0]        sel_q;
  logic [W-1:0]      expect_word;
  logic              restart, mismatch, bad_word;
  logic [W-1:0]      refill;
  logic [N_ACC-1:0]  acc_inc;
  logic [CNT_W-1:0]  acc_val [N_ACC];

  assign restart  = (pat_sel != sel_q);
  assign mismatch = (rx_data != expect_word);
  assign bad_word = rx_valid && mismatch;
  assign refill   = (link_up && !restart) ? expect_word : rx_data;

  prbs_ref_gen #(.W(W)) u_ref (
    .hist        (hist),
    .sel         (pat_sel),
    .expect_word (expect_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      sel_q    <= '0;
      word_err <= 1'b0;
    end else begin
      sel_q    <= pat_sel;
      word_err <= bad_word;
      if (rx_valid)
        hist <= HIST_W'({hist, refill});
    end
  end

  prbs_link_tracker #(.RUN_LEN(RUN_LEN)) u_link (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .valid   (rx_valid),
    .bad     (mismatch),
    .link    (link_up)
  );

  assign acc_inc = {bad_word, rx_valid};

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    prbs_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clear),
      .inc (acc_inc[g]),
      .q   (acc_val[g])
    );
  end

  assign word_count = acc_val[0];
  assign err_count  = acc_val[1];
endmodule

// File: rtl/prbs_link_checker_sva.sv
module prbs_link_checker_sva #(
  parameter int W     = 16,
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     rx_data,
  input logic             rx_valid,
  input logic [2:0]       pat_sel,
  input logic             cnt_clear,
  input logic             link_up,
  input logic             word_err,
  input logic [CNT_W-1:0] word_count,
  input logic [CNT_W-1:0] err_count
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!link_up && !word_err && word_count == '0 && err_count == '0));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !cnt_clear) |=>
      (!word_err && $stable(word_count) && $stable(err_count)));

  a_r11_sel_drop: assert property (@(posedge clk) disable iff (rst)
    (pat_sel != $past(pat_sel)) |=> !link_up);

  a_r4_rise_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> !word_err);

  a_r5_fall_errored: assert property (@(posedge clk) disable iff (rst)
    ($fell(link_up) && ($past(pat_sel) == $past(pat_sel, 2))) |-> word_err);

  a_r7_word_step: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cnt_clear && word_count != '1) |=>
      (word_count == $past(word_count) + 1'b1));

  a_r8_err_bounded: assert property (@(posedge clk) disable iff (rst)
    err_count <= word_count);

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> (word_count == '0 && err_count == '0));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (word_count == '1 && !cnt_clear) |=> (word_count == '1));
endmodule

bind prbs_link_checker prbs_link_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .pat_sel    (pat_sel),
  .cnt_clear  (cnt_clear),
  .link_up    (link_up),
  .word_err   (word_err),
  .word_count (word_count),
  .err_count  (err_count)
);

// File: tb/prbs_link_checker_test.sv
module prbs_link_checker_test;
  localparam int  W   = 16;
  localparam int  CW  = 10;
  localparam int  HW  = 31;
  localparam int  RUN = 5;
  localparam time TCK = 10;

  logic clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic          rst;
  logic [W-1:0]  rx_data;
  logic          rx_valid;
  logic [2:0]    pat_sel;
  logic          cnt_clear;
  logic          link_up, word_err;
  logic [CW-1:0] word_count, err_count;

  prbs_link_checker #(.W(W), .CNT_W(CW), .RUN_LEN(RUN)) uut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .pat_sel(pat_sel), .cnt_clear(cnt_clear), .link_up(link_up),
    .word_err(word_err), .word_count(word_count), .err_count(err_count)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [HW-1:0] m_hist, tx_hist;
  logic          m_link, m_err;
  int            m_clean, m_bad;
  logic [CW-1:0] m_wc, m_ec;
  logic [2:0]    m_sel, tx_sel;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ref_word(input logic [HW-1:0] h, input logic [2:0] sel);
    logic [HW+W-1:0] st;
    int ta, tb;
    bit inv;
    case (sel)
      3'd1: begin ta = 14; tb = 15; inv = 0; end
      3'd2: begin ta = 18; tb = 23; inv = 0; end
      3'd3: begin ta = 28; tb = 31; inv = 0; end
      3'd4: begin ta = 1;  tb = 1;  inv = 1; end
      3'd5: begin ta = 10; tb = 10; inv = 1; end
      default: begin ta = 6; tb = 7; inv = 0; end
    endcase
    st = {h, {W{1'b0}}};
    for (int p = W - 1; p >= 0; p--)
      st[p] = inv ? ~st[p+ta] : (st[p+ta] ^ st[p+tb]);
    return st[W-1:0];
  endfunction

  function automatic logic [HW-1:0] push(input logic [HW-1:0] h, input logic [W-1:0] w);
    return HW'({h, w});
  endfunction

  task automatic model_reset();
    m_hist = '0; m_link = 0; m_err = 0; m_clean = 0; m_bad = 0;
    m_wc = '0; m_ec = '0; m_sel = '0;
  endtask

  task automatic step(input logic [W-1:0] d, input logic v, input logic [2:0] s, input logic clr);
    logic restart, bad;
    logic [W-1:0] e;
    @(negedge clk);
    rx_data = d; rx_valid = v; pat_sel = s; cnt_clear = clr;
    restart = (s != m_sel);
    e       = ref_word(m_hist, s);
    bad     = v && (d != e);
    m_sel   = s;
    m_err   = bad;
    if (v) m_hist = push(m_hist, (m_link && !restart) ? e : d);
    if (clr) begin
      m_wc = '0; m_ec = '0;
    end else begin
      if (v && m_wc != '1) m_wc = m_wc + 1'b1;
      if (bad && m_ec != '1) m_ec = m_ec + 1'b1;
    end
    if (restart) begin
      m_link = 0; m_clean = 0; m_bad = 0;
    end else if (v) begin
      if (bad) begin
        m_clean = 0;
        if (m_bad < RUN) m_bad++;
        if (m_link && m_bad == RUN) m_link = 0;
      end else begin
        m_bad = 0;
        if (m_clean < RUN) m_clean++;
        if (!m_link && m_clean == RUN) m_link = 1;
      end
    end
    @(posedge clk);
    #1;
    chk("R2 word_err", 32'(word_err), 32'(m_err));
    chk("R4 link_up", 32'(link_up), 32'(m_link));
    chk("R7 word_count", 32'(word_count), 32'(m_wc));
    chk("R8 err_count", 32'(err_count), 32'(m_ec));
  endtask

  // send next transmitted word, optionally corrupted by xor mask
  task automatic send(input logic [W-1:0] mask, input logic [2:0] s, input logic clr);
    logic [W-1:0] w;
    w = ref_word(tx_hist, tx_sel);
    tx_hist = push(tx_hist, w);
    step(w ^ mask, 1'b1, s, clr);
  endtask

  task automatic idle(input logic [2:0] s);
    step(W'($urandom), 1'b0, s, 1'b0);
  endtask

  task automatic tx_start(input logic [2:0] s);
    tx_sel  = s;
    tx_hist = (s == 3'd4 || s == 3'd5) ? '0 : (HW'($urandom) | HW'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [CW-1:0] held;
    int burst;
    void'($urandom(32'd20240611));
    rst = 1; rx_data = '0; rx_valid = 0; pat_sel = '0; cnt_clear = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 link in reset", 32'(link_up), 0);
    chk("R1 err in reset", 32'(word_err), 0);
    chk("R1 wc in reset", 32'(word_count), 0);
    chk("R1 ec in reset", 32'(err_count), 0);
    @(negedge clk); rst = 0;
    model_reset();

    // Self-sync onto PRBS31 and acquire link (R3, R4)
    tx_start(3'd3);
    idle(3'd3);
    for (int i = 0; i < 8; i++) send('0, 3'd3, 0);
    chk("R4 link after sync", 32'(link_up), 1);
    // One corrupted word, next clean word not flagged (R3)
    send(16'h0100, 3'd3, 0);
    chk("R3 corrupted flagged", 32'(word_err), 1);
    send('0, 3'd3, 0);
    chk("R3 free-run no echo", 32'(word_err), 0);

    // Hysteresis runs (R5, R6)
    for (int i = 0; i < 4; i++) send(16'h0001, 3'd3, 0);
    send('0, 3'd3, 0);
    for (int i = 0; i < 4; i++) send(16'h8000, 3'd3, 0);
    chk("R6 run restarted, link held", 32'(link_up), 1);
    idle(3'd3);
    chk("R6 idle keeps run, link held", 32'(link_up), 1);
    send(16'h0010, 3'd3, 0);
    chk("R5 fifth error drops link", 32'(link_up), 0);
    for (int i = 0; i < 8; i++) send('0, 3'd3, 0);
    chk("R4 relock", 32'(link_up), 1);

    // Idle ignores data (R12)
    held = word_count;
    for (int i = 0; i < 3; i++) idle(3'd3);
    chk("R12 count held", 32'(word_count), 32'(held));
    chk("R12 no flag", 32'(word_err), 0);
    send('0, 3'd3, 0);
    chk("R12 history intact", 32'(word_err), 0);

    // Clear (R9)
    send(16'h0004, 3'd3, 1);
    chk("R9 wc cleared", 32'(word_count), 0);
    chk("R9 ec cleared", 32'(err_count), 0);
    chk("R9 link untouched", 32'(link_up), 1);

    // Select change (R11)
    idle(3'd1);
    chk("R11 link dropped", 32'(link_up), 0);

    // Code 6 behaves as code 0 (R2)
    tx_start(3'd0);
    for (int i = 0; i < 8; i++) send('0, 3'd6, 0);
    chk("R2 code 6 locks to code 0 stream", 32'(link_up), 1);

    // Random phase over all patterns
    for (int s = 0; s < 6; s++) begin
      tx_start(3'(s));
      idle(3'(s));
      burst = 0;
      for (int i = 0; i < 160; i++) begin
        logic [W-1:0] mask;
        mask = '0;
        if (burst > 0) begin
          mask = W'(1) << ($urandom % W); burst--;
        end else if ($urandom % 40 == 0) begin
          burst = 4 + ($urandom % 3);
        end else if ($urandom % 10 == 0) begin
          mask = W'(1) << ($urandom % W);
        end
        if ($urandom % 8 == 0) idle(3'(s));
        else send(mask, 3'(s), ($urandom % 50) == 0);
      end
    end

    // Saturation (R10)
    tx_start(3'd4);
    idle(3'd4);
    send('0, 3'd4, 1);
    for (int i = 0; i < 1030; i++) send('0, 3'd4, 0);
    chk("R10 word_count saturated", 32'(word_count), 32'(10'h3FF));
    send('0, 3'd4, 1);
    for (int i = 0; i < 1030; i++) send(16'h0001, 3'd4, 0);
    chk("R10 err_count saturated", 32'(err_count), 32'(10'h3FF));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule